// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a signed fixed-point multiply-accumulate datapath for dot products such as FIR filter taps. Each cycle with `valid_i` high it multiplies `a_i` by `b_i` at full double width. It adds that product to the accumulator and clamps the sum to the signed range of the accumulator word, so a sum of n products takes exactly n valid cycles. The clamp is applied on every step. An out-of-range partial sum is pinned at the limit before the next term arrives, so the final value can depend on the order of the terms. A wrapping accumulator would give a different answer.

`clear_i` starts a new dot product without an idle cycle. If `clear_i` comes with a valid operand pair, that first result is loaded as if the accumulator held zero. If it comes alone, the accumulator is zeroed. `mode_i` can instead select a plain saturating add or subtract of `a_i` and `b_i`, which goes through the same clamp and replaces the accumulator contents.

A small control state machine tracks the accumulator condition and drives the sticky saturation flag. Its states are:
- ST_IDLE: cleared or just out of reset.
- ST_ACCUM: holding results with no clamp since the last clear.
- ST_CLAMPED: at least one clamp since the last clear.

Its transitions are:
- T_START: ST_IDLE to ST_ACCUM on a valid step with no clamp.
- T_OVF: any state to ST_CLAMPED on a valid step that clamps.
- T_CLEAR: ST_ACCUM or ST_CLAMPED to ST_IDLE on a clear with no valid.
- T_RESTART: ST_CLAMPED to ST_ACCUM on a clear together with a valid step that does not clamp.
- T_HOLD: the state is kept in every other case.

Top module: `sat_mac`

## Requirements
- R1: With `valid_i`=1, `clear_i`=0 and MAC mode, `acc_o` one cycle later equals clamp(acc + a*b). The product is formed at full precision, so each valid cycle adds exactly one product.
- R2: A step result above 2^(W-1)-1 (127 for W=8) makes `acc_o` exactly 2^(W-1)-1.
- R3: A step result below -2^(W-1) (-128 for W=8) makes `acc_o` exactly -2^(W-1).
- R4: Clamping happens at every step, so the same terms in a different order can give a different sum. For example, 64, +70, -25 gives 102, while 64, +45 gives 109.
- R5: With `clear_i`=1 and `valid_i`=1, the result is computed with the accumulator taken as zero, with no extra cycle.
- R6: With `clear_i`=1 and `valid_i`=0, `acc_o` becomes 0 and `sat_o` becomes 0 one cycle later.
- R7: `sat_o` rises after any step that clamps. It stays high through later non-clamping steps until a clear.
- R8: The encoding of `mode_i` is as follows. 2'b00 and 2'b11 select MAC. 2'b01 sets the accumulator to clamp(a+b). 2'b10 sets it to clamp(a-b). Both the add and the subtract use the same clamp and the same sticky flag.
- R9: With `valid_i`=0 and `clear_i`=0, `acc_o` and `sat_o` hold their values whatever `a_i`, `b_i` and `mode_i` carry.
- R10: After reset, `acc_o` is 0 and `sat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new accumulation (accumulator taken as zero) |
| valid_i | input | 1 | Operand pair valid this cycle |
| mode_i | input | 2 | Operation select: 00/11 MAC, 01 add, 10 subtract |
| a_i | input | W | Signed operand A |
| b_i | input | W | Signed operand B |
| acc_o | output | W | Signed saturated accumulator |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The assertions take the operands to be two's complement values of width W and `mode_i` to be known whenever `valid_i` is high. They also assume that `clear_i` and `valid_i` are sampled only at the rising edge. The stimulus changes inputs just after a rising edge and keeps them steady for a full cycle. It drives extreme operands such as -128*-128 and -128*127 on purpose, so both clamp limits and the widest product are reached. The scoreboard model clamps after every step, so order-dependent sums are predicted independently of the RTL.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

    typedef enum logic [1:0] {
        OP_MAC  = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_MACX = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_ACCUM   = 2'b01,
        ST_CLAMPED = 2'b10
    } mac_state_e;

endpackage

// File: rtl/sat_mac_mul.sv
module sat_mac_mul #(
    parameter int W = 8
) (
    input  logic signed [W-1:0]   a_i,
    input  logic signed [W-1:0]   b_i,
    output logic signed [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] b_x;

    assign a_x    = {{(PW-W){a_i[W-1]}}, a_i};
    assign b_x    = {{(PW-W){b_i[W-1]}}, b_i};
    assign prod_o = a_x * b_x;

endmodule

// File: rtl/sat_mac_clamp.sv
module sat_mac_clamp #(
    parameter int IN_W  = 17,
    parameter int OUT_W = 8
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o,
    output logic                    over_o,
    output logic                    under_o
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             fits;

    assign top_bits = val_i[IN_W-1:OUT_W-1];
    assign fits     = (top_bits == '0) || (top_bits == '1);
    assign over_o   = !fits && !val_i[IN_W-1];
    assign under_o  = !fits &&  val_i[IN_W-1];

    always_comb begin
        if (over_o)
            val_o = {1'b0, {(OUT_W-1){1'b1}}};
        else if (under_o)
            val_o = {1'b1, {(OUT_W-1){1'b0}}};
        else
            val_o = val_i[OUT_W-1:0];
    end

endmodule

// File: rtl/sat_mac_ctrl.sv
module sat_mac_ctrl
    import sat_mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic valid_i,
    input  logic clip_i,
    output logic acc_load_o,
    output logic acc_zero_o,
    output logic sat_o
);
    mac_state_e state_q;
    mac_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (valid_i)
                    state_d = clip_i ? ST_CLAMPED : ST_ACCUM;          // T_OVF / T_START
            end
            ST_ACCUM: begin
                if (clear_i && !valid_i)
                    state_d = ST_IDLE;                                 // T_CLEAR
                else if (valid_i && clip_i)
                    state_d = ST_CLAMPED;                              // T_OVF
            end
            ST_CLAMPED: begin
                if (clear_i && !valid_i)
                    state_d = ST_IDLE;                                 // T_CLEAR
                else if (clear_i && valid_i && !clip_i)
                    state_d = ST_ACCUM;                                // T_RESTART
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_load_o = valid_i;
        acc_zero_o = clear_i && !valid_i;
        sat_o      = (state_q == ST_CLAMPED);
    end

    // R7: sticky flag holds until a clear
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_o && !clear_i) |=> sat_o);

    // R6: a lone clear returns the controller to idle
    a_r6_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !valid_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import sat_mac_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                valid_i,
    input  logic [1:0]          mode_i,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] acc_o,
    output logic                sat_o
);
    localparam int PW    = 2 * W;
    localparam int SUM_W = PW + 1;
    localparam logic signed [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0]     acc_q;
    logic signed [W-1:0]     base;
    logic signed [PW-1:0]    prod;
    logic signed [SUM_W-1:0] sum_full;
    logic signed [SUM_W-1:0] base_x;
    logic signed [SUM_W-1:0] prod_x;
    logic signed [SUM_W-1:0] a_x;
    logic signed [SUM_W-1:0] b_x;
    logic signed [W-1:0]     clamped;
    logic                    clip_hi;
    logic                    clip_lo;
    logic                    acc_load;
    logic                    acc_zero;
    mac_op_e                 op;

    sat_mac_mul #(.W(W)) mul_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    assign op     = mac_op_e'(mode_i);
    assign base   = clear_i ? '0 : acc_q;
    assign base_x = {{(SUM_W-W){base[W-1]}}, base};
    assign prod_x = {prod[PW-1], prod};
    assign a_x    = {{(SUM_W-W){a_i[W-1]}}, a_i};
    assign b_x    = {{(SUM_W-W){b_i[W-1]}}, b_i};

    always_comb begin
        unique case (op)
            OP_ADD:  sum_full = a_x + b_x;
            OP_SUB:  sum_full = a_x - b_x;
            default: sum_full = base_x + prod_x;
        endcase
    end

    sat_mac_clamp #(.IN_W(SUM_W), .OUT_W(W)) clamp_i (
        .val_i   (sum_full),
        .val_o   (clamped),
        .over_o  (clip_hi),
        .under_o (clip_lo)
    );

    sat_mac_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .valid_i    (valid_i),
        .clip_i     (clip_hi || clip_lo),
        .acc_load_o (acc_load),
        .acc_zero_o (acc_zero),
        .sat_o      (sat_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (acc_zero)
            acc_q <= '0;
        else if (acc_load)
            acc_q <= clamped;
    end

    assign acc_o = acc_q;

    a_r2_clip_max: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && clip_hi) |=> (acc_o == ACC_MAX) && sat_o);

    a_r3_clip_min: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && clip_lo) |=> (acc_o == ACC_MIN) && sat_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clear_i) |=> $stable(acc_o) && $stable(sat_o));

    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !valid_i) |=> (acc_o == '0) && !sat_o);

    a_r1_no_clip_no_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clip_hi && !clip_lo && (clear_i || !sat_o)) |=> !sat_o);

endmodule

// File: tb/sat_mac_tb_top.sv
`timescale 1ns/1ps
module sat_mac_tb_top;
    localparam int W = 8;
    localparam int HI = (1 << (W-1)) - 1;
    localparam int LO = -(1 << (W-1));

    typedef struct {
        int    acc;
        bit    sat;
        int    due;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0;
    logic valid_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic signed [W-1:0] a_i = '0;
    logic signed [W-1:0] b_i = '0;
    logic signed [W-1:0] acc_o;
    logic sat_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int m_acc = 0;
    bit m_sat = 1'b0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sat_mac #(.W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .valid_i (valid_i),
        .mode_i  (mode_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .acc_o   (acc_o),
        .sat_o   (sat_o)
    );

    function automatic int clampv(int v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    task automatic drive(bit clr, bit vld, logic [1:0] md, int a, int b, string tag);
        int raw;
        exp_t e;
        @(posedge clk);
        #1;
        clear_i = clr;
        valid_i = vld;
        mode_i  = md;
        a_i     = a[W-1:0];
        b_i     = b[W-1:0];
        if (vld) begin
            if (md == 2'b01)      raw = a + b;
            else if (md == 2'b10) raw = a - b;
            else                  raw = (clr ? 0 : m_acc) + a * b;
            if (clr) m_sat = 1'b0;
            if (raw != clampv(raw)) m_sat = 1'b1;
            m_acc = clampv(raw);
        end else if (clr) begin
            m_acc = 0;
            m_sat = 1'b0;
        end
        e.acc = m_acc;
        e.sat = m_sat;
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (int'(acc_o) != e.acc || sat_o != e.sat) begin
                n_fail++;
                $display("FAIL %s: acc=%0d sat=%0b expected acc=%0d sat=%0b",
                         e.tag, acc_o, sat_o, e.acc, e.sat);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (acc_o !== '0 || sat_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: acc=%0d sat=%0b expected acc=0 sat=0", acc_o, sat_o);
        end
        rst_n = 1'b1;

        drive(1, 1, 2'b00, 3, 4, "R5");      // 12
        drive(0, 1, 2'b00, 5, -2, "R1");     // 2
        drive(0, 1, 2'b00, -7, 3, "R1");     // -19
        drive(0, 0, 2'b00, 99, 99, "R9");    // hold
        drive(0, 0, 2'b01, -50, 7, "R9");    // hold
        drive(0, 1, 2'b00, 100, 100, "R2");  // 127, flag
        drive(0, 1, 2'b00, -1, 10, "R7");    // 117, flag kept
        drive(1, 0, 2'b00, 5, 5, "R6");      // 0
        drive(1, 1, 2'b00, -128, 127, "R3"); // -128
        drive(1, 1, 2'b00, -128, -128, "R2"); // 127
        drive(1, 1, 2'b01, 64, 69, "R8");    // 127 flag
        drive(1, 1, 2'b10, -127, 5, "R8");   // -128 flag
        drive(1, 1, 2'b01, 10, 20, "R8");    // 30
        drive(0, 1, 2'b11, 2, 3, "R8");      // 36
        drive(0, 1, 2'b10, 3, 50, "R8");     // -47
        drive(1, 1, 2'b00, 64, 1, "R4");     // 64
        drive(0, 1, 2'b00, 70, 1, "R4");     // 127
        drive(0, 1, 2'b00, -25, 1, "R4");    // 102
        drive(1, 1, 2'b00, 64, 1, "R4");     // 64
        drive(0, 1, 2'b00, 45, 1, "R4");     // 109
        for (int i = 0; i < 8; i++)
            drive(i == 0, 1, 2'b00, i * 5 - 17, 3 - i, "R1");
        drive(1, 0, 2'b00, 0, 0, "R6");
        drive(0, 0, 2'b00, 0, 0, "R9");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule